// File: doc/BRIEF.md
# Per-Port Clear-On-Read Ethernet Statistics Bank

This block keeps the traffic statistics of a group of Ethernet ports. Each port owns 42 word-sized slots. Most slots are single event counters. Six slots hold three 64-bit byte totals, each split into two words. The receive and transmit MACs of every port pulse event flags and report frame completions with a length and a good/bad status. The bank turns those pulses into counter updates, sorts frame lengths into seven size classes and adds lengths into the byte totals.

A host reads the counters over a simple read port. A read returns the word one cycle after the request, and reading a counter clears it. The host must therefore poll each word before it saturates. A byte total is read low word first. That read latches the upper half, so the following high-word read returns a value that matches the low word, and the high-word read clears the whole total.

The read port is driven by a two-state sequencer. In `RD_IDLE` no reply is pending. It moves to `RD_REPLY` when `rd_en` is sampled high. It stays in `RD_REPLY` while `rd_en` stays high, for back-to-back reads, and returns to `RD_IDLE` on a cycle without a request.

Top module: `mac_stats_bank`

## Requirements
- R1: A read request (`rd_en` high at a clock edge) gives `rd_valid` high and the word on `rd_data` during the following cycle. A cycle without a request leaves `rd_valid` low in the next cycle.
- R2: Reading an event counter returns its value and sets it to zero.
- R3: If an event hits a counter in the same cycle that the counter is read, the read returns the old value and the counter afterwards holds 1. A byte total whose high word is read in the same cycle as a frame afterwards holds that frame's length.
- R4: Event counters stop at 2^CNT_W-1 and do not wrap. Byte totals stop at 2^(2*CNT_W)-1.
- R5: A finished frame falls into one of seven size classes: len ≤ 64, 65–127, 128–255, 256–511, 512–1023, 1024–1518, ≥ 1519. The receive classes (words 7..13) count good received frames only. The transmit classes (words 25..31) count every transmitted frame.
- R6: Good received frames add their length to the total at words 15/16. Bad received frames add to words 17/18. Transmitted frames add to words 33/34. The low word comes first.
- R7: Reading a low byte word does not clear the total and latches the upper half. The next read of the high word returns that latched value and clears the whole 64-bit total.
- R8: Receive flag bits map to words as follows. Bits 0..6 (broadcast, pause, multicast, FCS error, alignment error, runt, fragment) go to words 0..6. Bit 7 (too long) goes to word 14, bit 8 (overflow) to word 19 and bit 9 (filtered) to word 20. Transmit flag bits 0..3 (broadcast, pause, multicast, underrun) go to words 21..24 and bit 4 (oversize) to word 32. Transmit bits 5..11 (collision, abort collision, multiple collision, single collision, excessive deferral, deferral, late collision) go to words 35..41.
- R9: The word of port p, slot w is at byte address BASE_ADDR + p*0x100 + 4*w. An address below the base, beyond the last port, not a multiple of 4, or with w ≥ 42 returns 0 and clears nothing.
- R10: Events of one port change only that port's words.
- R11: After reset every word reads 0 and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done | input | NUM_PORTS | Per port: a received frame finished this cycle |
| rx_good | input | NUM_PORTS | Per port: the finished received frame is good |
| rx_len | input | NUM_PORTS*LEN_W | Per port: length of the finished received frame in bytes |
| rx_ev | input | NUM_PORTS*10 | Per port: receive event flags, one cycle per event |
| tx_done | input | NUM_PORTS | Per port: a transmitted frame finished this cycle |
| tx_len | input | NUM_PORTS*LEN_W | Per port: length of the finished transmitted frame |
| tx_ev | input | NUM_PORTS*12 | Per port: transmit event flags, one cycle per event |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_valid | output | 1 | Read reply valid |
| rd_data | output | CNT_W | Read reply word |

## Verification
The bench builds the bank with two ports, 8-bit counters and 12-bit lengths. Narrow counters let a few hundred event pulses, or twenty long frames, reach both the event-counter and the byte-total ceilings. Two ports are enough to show that events stay within their own port. With 84 words in total, every word can be read after each stimulus phase and compared against an arithmetic model. The phases cover every flag bit, frame lengths on both sides of each size-class boundary, and the snapshot/clear order of the split byte totals.

// File: rtl/mac_stats_pkg.sv
package mac_stats_pkg;
    localparam int NUM_RX_EV    = 10;
    localparam int NUM_TX_EV    = 12;
    localparam int NUM_BUCKETS  = 7;
    localparam int NUM_WORDS    = 42;
    localparam int NUM_BYTE_CNT = 3;
    localparam int PORT_STRIDE  = 256;
    localparam int WORD_W       = 6;
    localparam int RX_BKT_WORD  = 7;
    localparam int TX_BKT_WORD  = 25;
    localparam int unsigned BKT_LIMIT [NUM_BUCKETS-1] = '{64, 127, 255, 511, 1023, 1518};

    typedef enum logic {RD_IDLE, RD_REPLY} rd_state_e;

    function automatic int rx_ev_word(input int i);
        if (i < 7)  return i;
        if (i == 7) return 14;
        if (i == 8) return 19;
        return 20;
    endfunction

    function automatic int tx_ev_word(input int i);
        if (i < 4)  return 21 + i;
        if (i == 4) return 32;
        return 30 + i;
    endfunction

    function automatic int byte_lo_word(input int k);
        if (k == 0) return 15;
        if (k == 1) return 17;
        return 33;
    endfunction

    function automatic bit is_byte_word(input int w);
        return (w >= 15 && w <= 18) || w == 33 || w == 34;
    endfunction
endpackage

// File: rtl/mac_stats_bucket.sv
module mac_stats_bucket
    import mac_stats_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic [LEN_W-1:0]       len,
    output logic [NUM_BUCKETS-1:0] onehot
);
    int idx;

    always_comb begin
        idx = NUM_BUCKETS - 1;
        for (int b = NUM_BUCKETS - 2; b >= 0; b--) begin
            if (len <= LEN_W'(BKT_LIMIT[b])) idx = b;
        end
        onehot = NUM_BUCKETS'(1) << idx;
    end
endmodule

// File: rtl/mac_stats_port.sv
module mac_stats_port
    import mac_stats_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_done,
    input  logic                 rx_good,
    input  logic [LEN_W-1:0]     rx_len,
    input  logic [NUM_RX_EV-1:0] rx_ev,
    input  logic                 tx_done,
    input  logic [LEN_W-1:0]     tx_len,
    input  logic [NUM_TX_EV-1:0] tx_ev,
    input  logic                 rd_hit,
    input  logic [WORD_W-1:0]    rd_word,
    output logic [CNT_W-1:0]     rd_word_val
);
    localparam int TOT_W = 2 * CNT_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NUM_BUCKETS-1:0] rx_oh, tx_oh;
    logic [CNT_W-1:0]       word_val [NUM_WORDS];

    mac_stats_bucket #(.LEN_W(LEN_W)) u_rx_bkt (.len(rx_len), .onehot(rx_oh));
    mac_stats_bucket #(.LEN_W(LEN_W)) u_tx_bkt (.len(tx_len), .onehot(tx_oh));

    // Single-word event counters
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        if (!is_byte_word(w)) begin : g_cnt
            localparam logic [WORD_W-1:0] WI = WORD_W'(w);
            logic             ev_hit, bkt_hit, hit, clr;
            logic [CNT_W-1:0] cnt_q, base, nxt;

            if (w >= RX_BKT_WORD && w < RX_BKT_WORD + NUM_BUCKETS) begin : g_rxb
                assign bkt_hit = rx_done & rx_good & rx_oh[w - RX_BKT_WORD];
            end else if (w >= TX_BKT_WORD && w < TX_BKT_WORD + NUM_BUCKETS) begin : g_txb
                assign bkt_hit = tx_done & tx_oh[w - TX_BKT_WORD];
            end else begin : g_nob
                assign bkt_hit = 1'b0;
            end

            always_comb begin
                ev_hit = 1'b0;
                for (int i = 0; i < NUM_RX_EV; i++)
                    if (rx_ev_word(i) == w) ev_hit = ev_hit | rx_ev[i];
                for (int i = 0; i < NUM_TX_EV; i++)
                    if (tx_ev_word(i) == w) ev_hit = ev_hit | tx_ev[i];
            end

            assign hit  = ev_hit | bkt_hit;
            assign clr  = rd_hit && (rd_word == WI);
            assign base = clr ? '0 : cnt_q;
            assign nxt  = (hit && base != CNT_MAX) ? base + 1'b1 : base;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= nxt;
            end
            assign word_val[w] = cnt_q;
        end
    end

    // Split 64-bit byte totals with high-half snapshot
    for (genvar k = 0; k < NUM_BYTE_CNT; k++) begin : g_bytes
        localparam logic [WORD_W-1:0] LO = WORD_W'(byte_lo_word(k));
        localparam logic [WORD_W-1:0] HI = WORD_W'(byte_lo_word(k) + 1);
        logic             add_en, rd_lo, rd_hi;
        logic [LEN_W-1:0] add_len;
        logic [TOT_W-1:0] tot_q, base, nxt;
        logic [TOT_W:0]   sum;
        logic [CNT_W-1:0] snap_q;

        if (k == 0) begin : g_good
            assign add_en  = rx_done & rx_good;
            assign add_len = rx_len;
        end else if (k == 1) begin : g_bad
            assign add_en  = rx_done & ~rx_good;
            assign add_len = rx_len;
        end else begin : g_tx
            assign add_en  = tx_done;
            assign add_len = tx_len;
        end

        assign rd_lo = rd_hit && (rd_word == LO);
        assign rd_hi = rd_hit && (rd_word == HI);
        assign base  = rd_hi ? '0 : tot_q;
        assign sum   = {1'b0, base} + {{(TOT_W + 1 - LEN_W){1'b0}}, add_len};
        assign nxt   = !add_en ? base : (sum[TOT_W] ? '1 : sum[TOT_W-1:0]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tot_q  <= '0;
                snap_q <= '0;
            end else begin
                tot_q <= nxt;
                if (rd_lo) snap_q <= tot_q[TOT_W-1:CNT_W];
            end
        end

        assign word_val[byte_lo_word(k)]     = tot_q[CNT_W-1:0];
        assign word_val[byte_lo_word(k) + 1] = snap_q;
    end

    assign rd_word_val = word_val[rd_word];
endmodule

// File: rtl/mac_stats_bank.sv
module mac_stats_bank
    import mac_stats_pkg::*;
#(
    parameter int          NUM_PORTS = 6,
    parameter int          CNT_W     = 32,
    parameter int          LEN_W     = 14,
    parameter int          ADDR_W    = 18,
    parameter int unsigned BASE_ADDR = 32'h2_0000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS-1:0]           rx_done,
    input  logic [NUM_PORTS-1:0]           rx_good,
    input  logic [NUM_PORTS*LEN_W-1:0]     rx_len,
    input  logic [NUM_PORTS*NUM_RX_EV-1:0] rx_ev,
    input  logic [NUM_PORTS-1:0]           tx_done,
    input  logic [NUM_PORTS*LEN_W-1:0]     tx_len,
    input  logic [NUM_PORTS*NUM_TX_EV-1:0] tx_ev,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic                           rd_valid,
    output logic [CNT_W-1:0]               rd_data
);
    localparam int PORT_W = $clog2(NUM_PORTS);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(NUM_PORTS * PORT_STRIDE);
    localparam logic [WORD_W-1:0] NW     = WORD_W'(NUM_WORDS);

    logic [ADDR_W-1:0] offset;
    logic [PORT_W-1:0] sel_port;
    logic [WORD_W-1:0] sel_word;
    logic              acc_ok;
    logic [CNT_W-1:0]  port_val [NUM_PORTS];
    rd_state_e         state_q, state_d;
    logic [CNT_W-1:0]  data_q;

    assign offset   = rd_addr - BASE_A;
    assign sel_port = offset[8 +: PORT_W];
    assign sel_word = offset[7:2];
    assign acc_ok   = (rd_addr >= BASE_A) && (offset < SPAN) &&
                      (offset[1:0] == 2'b00) && (sel_word < NW);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mac_stats_port #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .rx_done    (rx_done[p]),
            .rx_good    (rx_good[p]),
            .rx_len     (rx_len[p*LEN_W +: LEN_W]),
            .rx_ev      (rx_ev[p*NUM_RX_EV +: NUM_RX_EV]),
            .tx_done    (tx_done[p]),
            .tx_len     (tx_len[p*LEN_W +: LEN_W]),
            .tx_ev      (tx_ev[p*NUM_TX_EV +: NUM_TX_EV]),
            .rd_hit     (rd_en && acc_ok && (sel_port == PORT_W'(p))),
            .rd_word    (sel_word),
            .rd_word_val(port_val[p])
        );
    end

    // Read sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (rd_en)  state_d = RD_REPLY;
            RD_REPLY: if (!rd_en) state_d = RD_IDLE;
        endcase
    end

    // Read sequencer: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     data_q <= '0;
        else if (rd_en) data_q <= acc_ok ? port_val[sel_port] : '0;
    end

    assign rd_valid = (state_q == RD_REPLY);
    assign rd_data  = data_q;
endmodule

// File: rtl/mac_stats_bank_chk.sv
module mac_stats_bank_chk
    import mac_stats_pkg::*;
#(
    parameter int          NUM_PORTS = 6,
    parameter int          CNT_W     = 32,
    parameter int          ADDR_W    = 18,
    parameter int unsigned BASE_ADDR = 32'h2_0000
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_PORTS-1:0]           rx_done,
    input logic [NUM_PORTS*NUM_RX_EV-1:0] rx_ev,
    input logic [NUM_PORTS-1:0]           tx_done,
    input logic [NUM_PORTS*NUM_TX_EV-1:0] tx_ev,
    input logic                           rd_en,
    input logic [ADDR_W-1:0]              rd_addr,
    input logic                           rd_valid,
    input logic [CNT_W-1:0]               rd_data
);
    logic [ADDR_W-1:0] rel;
    logic              good_addr, single_word, quiet;
    logic              q_rd, q_quiet;
    logic [ADDR_W-1:0] q_addr;

    assign rel         = rd_addr - ADDR_W'(BASE_ADDR);
    assign good_addr   = (rd_addr >= ADDR_W'(BASE_ADDR)) &&
                         (rel < ADDR_W'(NUM_PORTS * PORT_STRIDE)) &&
                         (rel[1:0] == 2'b00) && (int'(rel[7:2]) < NUM_WORDS);
    assign single_word = !is_byte_word(int'(rel[7:2]));
    assign quiet       = !(|rx_done) && !(|rx_ev) && !(|tx_done) && !(|tx_ev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_rd    <= 1'b0;
            q_quiet <= 1'b0;
            q_addr  <= '0;
        end else begin
            q_rd    <= rd_en;
            q_quiet <= quiet;
            q_addr  <= rd_addr;
        end
    end

    a_r1_reply_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r1_no_spurious_reply: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    a_r9_bad_addr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !good_addr) |=> (rd_data == '0));

    a_r2_cleared_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && q_rd && q_quiet && rd_addr == q_addr && good_addr && single_word)
        |=> (rd_data == '0));
endmodule

bind mac_stats_bank mac_stats_bank_chk #(
    .NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (.*);

// File: tb/mac_stats_bank_test.sv
module mac_stats_bank_test;
    localparam int P  = 2;
    localparam int CW = 8;
    localparam int LW = 12;
    localparam int AW = 18;
    localparam longint MAXC = 255;
    localparam longint MAXT = 65535;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [P-1:0]  rx_done = '0, rx_good = '0, tx_done = '0;
    logic [P*LW-1:0] rx_len = '0, tx_len = '0;
    logic [P*10-1:0] rx_ev = '0;
    logic [P*12-1:0] tx_ev = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid;
    logic [CW-1:0] rd_data;

    int checks = 0, fails = 0;
    bit done = 0;

    longint cnt [P][42];
    longint tot [P][3];
    longint snp [P][3];

    always #4 clk = ~clk;

    mac_stats_bank #(.NUM_PORTS(P), .CNT_W(CW), .LEN_W(LW), .ADDR_W(AW)) uut (.*);

    function automatic logic [AW-1:0] waddr(int p, int w);
        return AW'(32'h2_0000 + p * 256 + w * 4);
    endfunction

    function automatic int rx_word(int i);
        int m [10] = '{0, 1, 2, 3, 4, 5, 6, 14, 19, 20};
        return m[i];
    endfunction

    function automatic int tx_word(int i);
        int m [12] = '{21, 22, 23, 24, 32, 35, 36, 37, 38, 39, 40, 41};
        return m[i];
    endfunction

    function automatic int size_class(int len);
        if (len <= 64)   return 0;
        if (len <= 127)  return 1;
        if (len <= 255)  return 2;
        if (len <= 511)  return 3;
        if (len <= 1023) return 4;
        if (len <= 1518) return 5;
        return 6;
    endfunction

    function automatic int tot_idx(int w);
        if (w == 15 || w == 16) return 0;
        if (w == 17 || w == 18) return 1;
        if (w == 33 || w == 34) return 2;
        return -1;
    endfunction

    function automatic longint model_read(int p, int w);
        int k = tot_idx(w);
        longint r;
        if (k < 0) begin
            r = cnt[p][w];
            cnt[p][w] = 0;
        end else if (w == 15 || w == 17 || w == 33) begin
            r = tot[p][k] & MAXC;
            snp[p][k] = (tot[p][k] >> CW) & MAXC;
        end else begin
            r = snp[p][k];
            tot[p][k] = 0;
        end
        return r;
    endfunction

    function automatic void bump(int p, int w);
        if (cnt[p][w] < MAXC) cnt[p][w]++;
    endfunction

    function automatic void add_tot(int p, int k, int len);
        tot[p][k] = (tot[p][k] + len > MAXT) ? MAXT : tot[p][k] + len;
    endfunction

    function automatic void model_rx(int p, int len, bit good);
        if (good) begin
            bump(p, 7 + size_class(len));
            add_tot(p, 0, len);
        end else add_tot(p, 1, len);
    endfunction

    function automatic void model_tx(int p, int len);
        bump(p, 25 + size_class(len));
        add_tot(p, 2, len);
    endfunction

    function automatic void note(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endfunction

    task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] d, output logic v);
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
        v = rd_valid;
        rd_en = 1'b0;
    endtask

    task automatic chk(int p, int w, string tag);
        logic [CW-1:0] d;
        logic v;
        longint e = model_read(p, w);
        rd(waddr(p, w), d, v);
        note(d == CW'(e) && v === 1'b1, tag, {v, d}, {1'b1, CW'(e)});
    endtask

    task automatic chk_all(string tag);
        for (int p = 0; p < P; p++)
            for (int w = 0; w < 42; w++) chk(p, w, tag);
    endtask

    task automatic pulse_rx_ev(int p, int i, int n);
        for (int j = 0; j < n; j++) begin
            rx_ev[p*10 + i] = 1'b1;
            bump(p, rx_word(i));
            @(negedge clk);
            rx_ev[p*10 + i] = 1'b0;
        end
    endtask

    task automatic pulse_tx_ev(int p, int i, int n);
        for (int j = 0; j < n; j++) begin
            tx_ev[p*12 + i] = 1'b1;
            bump(p, tx_word(i));
            @(negedge clk);
            tx_ev[p*12 + i] = 1'b0;
        end
    endtask

    task automatic rx_frame(int p, int len, bit good);
        rx_done[p] = 1'b1;
        rx_good[p] = good;
        rx_len[p*LW +: LW] = LW'(len);
        model_rx(p, len, good);
        @(negedge clk);
        rx_done[p] = 1'b0;
        rx_good[p] = 1'b0;
    endtask

    task automatic tx_frame(int p, int len);
        tx_done[p] = 1'b1;
        tx_len[p*LW +: LW] = LW'(len);
        model_tx(p, len);
        @(negedge clk);
        tx_done[p] = 1'b0;
    endtask

    task automatic bad_addr(logic [AW-1:0] a);
        logic [CW-1:0] d;
        logic v;
        rd(a, d, v);
        note(d == '0, "R9 invalid address reads zero", d, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] d;
        logic v;
        longint e;
        int lens [14] = '{40, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 4095};

        for (int p = 0; p < P; p++) begin
            for (int w = 0; w < 42; w++) cnt[p][w] = 0;
            for (int k = 0; k < 3; k++) begin tot[p][k] = 0; snp[p][k] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        note(rd_valid === 1'b0, "R11 rd_valid low after reset", rd_valid, 0);
        chk_all("R11 reset value");

        // R8 / R10: every flag bit, distinct counts per port
        for (int p = 0; p < P; p++) begin
            for (int i = 0; i < 10; i++) pulse_rx_ev(p, i, i + 1 + 3 * p);
            for (int i = 0; i < 12; i++) pulse_tx_ev(p, i, 12 - i + p);
        end
        chk_all("R8/R10 flag mapping");
        chk_all("R2 cleared after read");

        // R5 / R6: size class boundaries, good/bad and transmit byte totals
        for (int j = 0; j < 14; j++) rx_frame(0, lens[j], 1'b1);
        for (int j = 0; j < 4; j++)  rx_frame(0, lens[j + 5], 1'b0);
        for (int j = 0; j < 14; j++) tx_frame(1, lens[13 - j]);
        chk_all("R5/R6/R10 classes and byte totals");

        // R7: low read latches high half; high read clears whole total
        rx_frame(0, 300, 1'b1);
        chk(0, 15, "R7 low word");
        chk(0, 15, "R7 low read does not clear");
        rx_frame(0, 300, 1'b1);
        chk(0, 16, "R7 high word from snapshot");
        chk(0, 15, "R7 total cleared by high read");
        chk(0, 16, "R7 high after clear");

        // R3: event coinciding with a read of the same counter
        pulse_rx_ev(1, 0, 3);
        rx_ev[10] = 1'b1;
        e = model_read(1, 0);
        bump(1, 0);
        rd(waddr(1, 0), d, v);
        rx_ev[10] = 1'b0;
        note(d == CW'(e), "R3 read during event returns old value", d, e);
        chk(1, 0, "R3 counter holds one after coincident read");
        rx_frame(1, 700, 1'b1);
        chk(1, 15, "R3 setup low word");
        rx_done[1] = 1'b1;
        rx_good[1] = 1'b1;
        rx_len[LW +: LW] = LW'(100);
        e = model_read(1, 16);
        model_rx(1, 100, 1'b1);
        rd(waddr(1, 16), d, v);
        rx_done[1] = 1'b0;
        rx_good[1] = 1'b0;
        note(d == CW'(e), "R3 high read during frame", d, e);
        chk_all("R3 totals after coincident frame");

        // R4: saturation of counters and byte totals
        pulse_tx_ev(0, 11, 300);
        chk(0, 41, "R4 event counter saturates");
        for (int j = 0; j < 20; j++) rx_frame(1, 4095, 1'b1);
        chk(1, 15, "R4 byte total saturates low");
        chk(1, 16, "R4 byte total saturates high");
        chk(1, 13, "R4 class count");

        // R9: bad addresses return zero and clear nothing
        pulse_rx_ev(0, 0, 5);
        bad_addr(AW'(32'h2_0000 - 4));
        bad_addr(AW'(32'h2_0002));
        bad_addr(AW'(32'h2_0000 + 42 * 4));
        bad_addr(AW'(32'h2_0000 + P * 256));
        bad_addr(AW'(0));
        chk(0, 0, "R9 counter untouched by bad reads");

        // R1: reply timing
        rd(waddr(0, 1), d, v);
        note(v === 1'b1, "R1 reply valid in following cycle", v, 1);
        @(negedge clk);
        note(rd_valid === 1'b0, "R1 no reply without request", rd_valid, 0);
        e = model_read(0, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule